// File: doc/BRIEF.md
# Channel Attention Initialisation Sequencer

This block is the front-end controller of an I/O processor. It responds to a channel-attention strobe by walking a chain of configuration records held in shared memory. A one-byte-per-request memory read/write port connects it to that memory. The same strobe does two different jobs, depending on whether the device has been initialised since reset.

The first attention after reset starts the boot walk. The sequencer reads a five-byte boot record at the fixed address 0xFFFF6. That record gives the system bus width and a pointer to the system configuration block. From that block it takes the private bus width, the request/grant mode and a pointer to the control block. It then clears the busy byte at the base of the control block, and from then on it counts as initialised. The select input taken at that first strobe picks the operating mode. Every later attention treats select as a channel number. For that channel it fetches the channel control word and the parameter-block pointer from the channel's slot in the control block.

The FSM has five states. ST_IDLE waits. ST_CFGPTR reads the boot record. ST_CFGBLK reads the configuration block. ST_CLRBUSY writes the busy byte. ST_CHAN reads a channel slot. The transitions are as follows:
- ST_IDLE goes to ST_CFGPTR on a falling attention edge while uninitialised.
- ST_IDLE goes to ST_CHAN on a falling attention edge once initialised.
- ST_CFGPTR goes to ST_CFGBLK on the acknowledge of its fifth byte.
- ST_CFGBLK goes to ST_CLRBUSY on the acknowledge of its fifth byte.
- ST_CLRBUSY goes to ST_IDLE on the acknowledge of its write.
- ST_CHAN goes to ST_IDLE on the acknowledge of its sixth byte.

Top module: `cas_init_seq`

## Requirements
- R1: After reset the sequencer is idle:
  - mem_req, done and inited are 0.
  - remote_mode, sys_wide, priv_wide, rqgt_mode and chan are 0.
  - ccw and pb_addr are 0.
- R2: A sequence starts only on a 1-to-0 transition of attn, and sel is taken in that same cycle. A steady or rising attn starts nothing.
- R3: On the first attention after reset, remote_mode becomes 1 when sel was 0 and 0 when sel was 1. It does not change afterwards until reset.
- R4: Initialisation reads bytes 0xFFFF6 through 0xFFFFA in ascending order:
  - Bit 0 of the first byte becomes sys_wide.
  - The next four bytes are the configuration-block pointer.
- R5: Every pointer is four bytes in this order: offset low, offset high, segment low, segment high. Its address is (segment × 16 + offset) modulo 2^20.
- R6: The configuration block is read from its base over five ascending bytes:
  - Bit 0 of byte 0 becomes priv_wide.
  - Bit 1 of byte 0 becomes rqgt_mode.
  - Bytes 1 to 4 are the control-block pointer.
- R7: Initialisation ends with exactly one write, of 0x00, to the control-block base, after which inited is 1. No write occurs at any other time.
- R8: Once initialised, an attention sets chan to sel. It then reads six ascending bytes starting at control-block base + 2 + 8 × sel, modulo 2^20:
  - The first two bytes are ccw, low byte first.
  - The last four bytes are the parameter-block pointer, which gives pb_addr.
- R9: An attention that falls while a sequence is running is ignored. It causes no extra access and does not change chan.
- R10: done is a one-cycle pulse. It occurs in the cycle after the acknowledge of the last access of each sequence, and at no other time.
- R11: mem_req stays high with mem_addr and mem_we unchanged until mem_ack. The next address appears only after that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attn | input | 1 | Channel-attention strobe; falling edge starts a sequence |
| sel | input | 1 | Mode select at first attention, channel select afterwards |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Access acknowledge, one cycle |
| mem_rdata | input | 8 | Read data, valid with mem_ack |
| done | output | 1 | Sequence complete pulse |
| inited | output | 1 | Initialisation finished |
| remote_mode | output | 1 | 1 = master/remote, 0 = slave/local |
| sys_wide | output | 1 | System bus width flag |
| priv_wide | output | 1 | Private bus width flag |
| rqgt_mode | output | 1 | Request/grant mode flag |
| chan | output | 1 | Last selected channel (0 = channel 1) |
| ccw | output | 16 | Channel control word |
| pb_addr | output | 20 | Parameter block address |

## Verification
The bench runs two boot images:
- The first has plain pointers and a master-mode strobe.
- The second has pointers whose segment-plus-offset sum passes 2^20, a channel slot that wraps through address zero, and a slave-mode strobe.

These images separate correct modulo addressing from carry leakage, and correct mode decoding from inverted select. Channel attentions for both select values show whether the slot stride and byte order are right. Acknowledge latencies of zero to two cycles test request holding. A held-high strobe, and a strobe pulsed during a running channel fetch, show whether the block reacts only to idle falling edges.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 3;
    localparam int CCW_W  = 2 * DATA_W;
    localparam int PTR_W  = 4 * DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFGPTR,
        ST_CFGBLK,
        ST_CLRBUSY,
        ST_CHAN
    } cas_state_e;

    // segment * 16 + offset, wrapped to the address width
    function automatic logic [ADDR_W-1:0] join_ptr(input logic [PTR_W-1:0] p);
        logic [ADDR_W-1:0] seg_part;
        logic [ADDR_W-1:0] off_part;
        seg_part = {p[PTR_W-1:16], 4'b0000};
        off_part = ADDR_W'(p[15:0]);
        return seg_part + off_part;
    endfunction

endpackage

// File: rtl/cas_fall_detect.sv
module cas_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fall
);
    logic strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe;
    end

    assign fall = strobe_q & ~strobe;
endmodule

// File: rtl/cas_addr_gen.sv
module cas_addr_gen
    import cas_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOOT_ADDR   = 20'hFFFF6,
    parameter int                CHAN_OFS    = 2,
    parameter int                CHAN_STRIDE = 8
) (
    input  cas_state_e        st,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ADDR_W-1:0] scb_base,
    input  logic [ADDR_W-1:0] cb_base,
    input  logic              chan,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] SLOT0 = ADDR_W'(CHAN_OFS);
    localparam logic [ADDR_W-1:0] SLOT1 = ADDR_W'(CHAN_OFS + CHAN_STRIDE);

    logic [ADDR_W-1:0] idx_ext;
    assign idx_ext = ADDR_W'(idx);

    always_comb begin
        unique case (st)
            ST_CFGPTR:  addr = BOOT_ADDR + idx_ext;
            ST_CFGBLK:  addr = scb_base + idx_ext;
            ST_CLRBUSY: addr = cb_base;
            ST_CHAN:    addr = cb_base + (chan ? SLOT1 : SLOT0) + idx_ext;
            default:    addr = '0;
        endcase
    end
endmodule

// File: rtl/cas_init_seq.sv
module cas_init_seq
    import cas_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BOOT_ADDR   = 20'hFFFF6,
    parameter int                CHAN_OFS    = 2,
    parameter int                CHAN_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attn,
    input  logic              sel,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic              inited,
    output logic              remote_mode,
    output logic              sys_wide,
    output logic              priv_wide,
    output logic              rqgt_mode,
    output logic              chan,
    output logic [CCW_W-1:0]  ccw,
    output logic [ADDR_W-1:0] pb_addr
);
    localparam logic [IDX_W-1:0] LAST_PTR_IDX  = IDX_W'(4);
    localparam logic [IDX_W-1:0] LAST_CHAN_IDX = IDX_W'(5);

    cas_state_e        state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [PTR_W-1:0]  ptr_full;
    logic [ADDR_W-1:0] scb_q, cb_q, joined;
    logic              attn_fall;

    cas_fall_detect u_fall (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (attn),
        .fall   (attn_fall)
    );

    cas_addr_gen #(
        .BOOT_ADDR   (BOOT_ADDR),
        .CHAN_OFS    (CHAN_OFS),
        .CHAN_STRIDE (CHAN_STRIDE)
    ) u_addr (
        .st       (state_q),
        .idx      (idx_q),
        .scb_base (scb_q),
        .cb_base  (cb_q),
        .chan     (chan),
        .addr     (mem_addr)
    );

    // pointer bytes arrive low first; the newest one lands on top
    assign ptr_full = {mem_rdata, ptr_q[PTR_W-1:DATA_W]};
    assign joined   = join_ptr(ptr_full);

    assign mem_req   = (state_q != ST_IDLE);
    assign mem_we    = (state_q == ST_CLRBUSY);
    assign mem_wdata = '0;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (attn_fall) state_d = inited ? ST_CHAN : ST_CFGPTR;
            ST_CFGPTR:
                if (mem_ack && idx_q == LAST_PTR_IDX) state_d = ST_CFGBLK;
            ST_CFGBLK:
                if (mem_ack && idx_q == LAST_PTR_IDX) state_d = ST_CLRBUSY;
            ST_CLRBUSY:
                if (mem_ack) state_d = ST_IDLE;
            ST_CHAN:
                if (mem_ack && idx_q == LAST_CHAN_IDX) state_d = ST_IDLE;
            default:
                state_d = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            ptr_q       <= '0;
            scb_q       <= '0;
            cb_q        <= '0;
            done        <= 1'b0;
            inited      <= 1'b0;
            remote_mode <= 1'b0;
            sys_wide    <= 1'b0;
            priv_wide   <= 1'b0;
            rqgt_mode   <= 1'b0;
            chan        <= 1'b0;
            ccw         <= '0;
            pb_addr     <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (attn_fall) begin
                        if (inited) chan        <= sel;
                        else        remote_mode <= ~sel;
                    end
                end
                ST_CFGPTR, ST_CFGBLK: begin
                    if (mem_ack) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == '0) begin
                            if (state_q == ST_CFGPTR) begin
                                sys_wide <= mem_rdata[0];
                            end else begin
                                priv_wide <= mem_rdata[0];
                                rqgt_mode <= mem_rdata[1];
                            end
                        end else begin
                            ptr_q <= ptr_full;
                        end
                        if (idx_q == LAST_PTR_IDX) begin
                            idx_q <= '0;
                            if (state_q == ST_CFGPTR) scb_q <= joined;
                            else                      cb_q  <= joined;
                        end
                    end
                end
                ST_CLRBUSY: begin
                    if (mem_ack) begin
                        inited <= 1'b1;
                        done   <= 1'b1;
                    end
                end
                ST_CHAN: begin
                    if (mem_ack) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == IDX_W'(0))      ccw[7:0]  <= mem_rdata;
                        else if (idx_q == IDX_W'(1)) ccw[15:8] <= mem_rdata;
                        else                         ptr_q     <= ptr_full;
                        if (idx_q == LAST_CHAN_IDX) begin
                            idx_q   <= '0;
                            pb_addr <= joined;
                            done    <= 1'b1;
                        end
                    end
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // R11: request, address and direction held until acknowledged
    a_r11_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10: done never lasts two cycles
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: done only follows an acknowledged access
    a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_ack));

    // R7: the only write is the zero to the busy byte, before initialisation
    a_r7_single_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (!inited && mem_wdata == '0));

    // R3: mode frozen once initialised
    a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        inited |=> $stable(remote_mode));

endmodule

// File: tb/sim_cas_init_seq.sv
module sim_cas_init_seq;
    localparam int CLK_P = 10;
    localparam int BOOT  = 'hFFFF6;
    localparam int AMASK = 'hFFFFF;

    typedef struct {
        int addr;
        bit we;
    } acc_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        attn = 1'b0;
    logic        sel = 1'b0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = 8'h00;
    logic        done, inited, remote_mode, sys_wide, priv_wide, rqgt_mode, chan;
    logic [15:0] ccw;
    logic [19:0] pb_addr;

    logic [7:0] mem [int];
    acc_t       q[$];
    bit         exp_done_next = 0;
    bit         model_inited = 0;
    bit         finished = 0;
    int         lat = 0;
    int         acc_no = 0;
    int         tests = 0;
    int         fails = 0;
    int         cb_model = 0;

    cas_init_seq u0 (
        .clk(clk), .rst_n(rst_n), .attn(attn), .sel(sel),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .inited(inited), .remote_mode(remote_mode),
        .sys_wide(sys_wide), .priv_wide(priv_wide), .rqgt_mode(rqgt_mode),
        .chan(chan), .ccw(ccw), .pb_addr(pb_addr)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [7:0] rd(int a);
        return mem.exists(a & AMASK) ? mem[a & AMASK] : 8'h00;
    endfunction

    function automatic int ptr_at(int a);
        int off, seg;
        off = rd(a) | (rd(a + 1) << 8);
        seg = rd(a + 2) | (rd(a + 3) << 8);
        return ((seg << 4) + off) & AMASK;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model: expected access stream, memory responder, done timing
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            exp_done_next = 0;
            lat = 0;
        end else begin
            chk("R10", "done timing", 32'(done), 32'(exp_done_next));
            exp_done_next = 0;
            if (mem_ack) begin
                mem_ack = 1'b0;
                lat = 0;
            end else if (q.size() == 0) begin
                chk("R9", "no request while idle", 32'(mem_req), 0);
            end else if (mem_req) begin
                chk("R11", "address", 32'(mem_addr), q[0].addr);
                chk("R7", "direction", 32'(mem_we), 32'(q[0].we));
                if (lat >= (acc_no % 3)) begin
                    mem_ack   = 1'b1;
                    mem_rdata = rd(int'(mem_addr));
                    if (mem_we) begin
                        chk("R7", "write data", 32'(mem_wdata), 0);
                        mem[int'(mem_addr)] = mem_wdata;
                    end
                    void'(q.pop_front());
                    acc_no++;
                    if (q.size() == 0) exp_done_next = 1;
                end else begin
                    lat++;
                end
            end else begin
                chk("R11", "request dropped early", 32'(mem_req), 1);
            end
        end
    end

    task automatic do_reset();
        @(posedge clk); #(CLK_P/4);
        rst_n = 1'b0; attn = 1'b0;
        q.delete();
        model_inited = 0;
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "mem_req", 32'(mem_req), 0);
        chk("R1", "done", 32'(done), 0);
        chk("R1", "inited", 32'(inited), 0);
        chk("R1", "flags", {27'd0, remote_mode, sys_wide, priv_wide, rqgt_mode, chan}, 0);
        chk("R1", "ccw", 32'(ccw), 0);
        chk("R1", "pb_addr", 32'(pb_addr), 0);
    endtask

    task automatic drop_attn(bit s);
        @(posedge clk); #(CLK_P/4);
        sel = s; attn = 1'b1;
        @(posedge clk); #(CLK_P/4);
        attn = 1'b0;
    endtask

    task automatic attention(bit s);
        int scb, slot;
        acc_t a;
        drop_attn(s);
        @(posedge clk); #(CLK_P/4);
        if (!model_inited) begin
            for (int i = 0; i < 5; i++) begin a.addr = BOOT + i; a.we = 0; q.push_back(a); end
            scb = ptr_at(BOOT + 1);
            for (int i = 0; i < 5; i++) begin a.addr = (scb + i) & AMASK; a.we = 0; q.push_back(a); end
            cb_model = ptr_at(scb + 1);
            a.addr = cb_model; a.we = 1; q.push_back(a);
            model_inited = 1;
        end else begin
            slot = cb_model + 2 + 8 * s;
            for (int i = 0; i < 6; i++) begin a.addr = (slot + i) & AMASK; a.we = 0; q.push_back(a); end
        end
    endtask

    task automatic wait_idle();
        while (q.size() != 0 || exp_done_next) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic check_init(bit s);
        int scb;
        scb = ptr_at(BOOT + 1);
        chk("R3", "remote_mode", 32'(remote_mode), 32'(!s));
        chk("R4", "sys_wide", 32'(sys_wide), 32'(rd(BOOT) & 1));
        chk("R6", "priv_wide", 32'(priv_wide), 32'(rd(scb) & 1));
        chk("R6", "rqgt_mode", 32'(rqgt_mode), 32'((rd(scb) >> 1) & 1));
        chk("R7", "inited", 32'(inited), 1);
        chk("R7", "busy byte cleared", 32'(rd(cb_model)), 0);
    endtask

    task automatic check_chan(bit s);
        int slot;
        slot = cb_model + 2 + 8 * s;
        chk("R8", "chan", 32'(chan), 32'(s));
        chk("R8", "ccw", 32'(ccw), rd(slot) | (rd(slot + 1) << 8));
        chk("R5", "pb_addr", 32'(pb_addr), ptr_at(slot + 2));
    endtask

    task automatic put(int a, logic [7:0] d);
        mem[a & AMASK] = d;
    endtask

    task automatic image_a();
        mem.delete();
        put('hFFFF6, 8'h01); put('hFFFF7, 8'h34); put('hFFFF8, 8'h12);
        put('hFFFF9, 8'h00); put('hFFFFA, 8'h50);
        put('h51234, 8'h02); put('h51235, 8'h10); put('h51236, 8'h00);
        put('h51237, 8'h00); put('h51238, 8'h20);
        put('h20010, 8'hFF);
        put('h20012, 8'hA5); put('h20013, 8'h3C); put('h20014, 8'h00);
        put('h20015, 8'h01); put('h20016, 8'h00); put('h20017, 8'h30);
        put('h2001A, 8'h5A); put('h2001B, 8'hC3); put('h2001C, 8'h08);
        put('h2001D, 8'h00); put('h2001E, 8'h40); put('h2001F, 8'h00);
    endtask

    task automatic image_b();
        mem.delete();
        put('hFFFF6, 8'h00); put('hFFFF7, 8'hFF); put('hFFFF8, 8'hFF);
        put('hFFFF9, 8'hFF); put('hFFFFA, 8'hFF);
        put('h0FFEF, 8'h01); put('h0FFF0, 8'hFE); put('h0FFF1, 8'hFF);
        put('h0FFF2, 8'h00); put('h0FFF3, 8'hF0);
        put('hFFFFE, 8'hFF);
        put('h00008, 8'h11); put('h00009, 8'h22); put('h0000A, 8'h34);
        put('h0000B, 8'h12); put('h0000C, 8'h00); put('h0000D, 8'h10);
    endtask

    initial begin
        image_a();
        do_reset();
        // R2: held-high strobe starts nothing (per-clock idle check)
        @(posedge clk); #(CLK_P/4);
        attn = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2", "no start on high level", 32'(mem_req), 0);
        attention(1'b0);
        wait_idle();
        check_init(1'b0);
        chk("R5", "ccw before channel fetch", 32'(ccw), 0);
        attention(1'b0);
        wait_idle();
        check_chan(1'b0);
        attention(1'b1);
        // R9: a second strobe during the fetch, opposite select
        drop_attn(1'b0);
        wait_idle();
        check_chan(1'b1);
        chk("R9", "chan unchanged by ignored strobe", 32'(chan), 1);
        // wrapped pointers, slave mode, slot wrapping through zero
        image_b();
        do_reset();
        attention(1'b1);
        wait_idle();
        check_init(1'b1);
        chk("R5", "wrapped control block base", cb_model, 'hFFFFE);
        attention(1'b1);
        wait_idle();
        check_chan(1'b1);
        chk("R8", "wrapped slot pb_addr", 32'(pb_addr), 'h11234);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule